// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host-side master for one conversion on a small 8-bit sampling serial converter. A one-cycle request carries the input configuration: single-ended or differential, which input is the positive one, and the order in which the result comes back. The block pulls chip select low and makes a serial clock from a fixed divider of the system clock. It sends a four-bit configuration word: a start bit of 1, then the single/differential bit, the channel bit and the bit-order bit. It then reads the reply on the converter's data output.

The data line may be a single wire shared by host and converter. For that case the block drives an output-enable. The enable goes low in the gap between the 4th rising and the 4th falling serial clock edge, so the converter can drive the wire from its 4th falling edge. The reply begins with a zero null bit, which the block discards. The eight result bits follow, most significant first. When LSB-first order is requested, the converter then sends bits 1 to 7 again in reverse order. The block reads these too and raises a mismatch flag if the two copies disagree.

The block registers each result and marks it with a one-cycle valid pulse. It then holds chip select high for a minimum number of system cycles before it accepts the next request.

Top module: `sadc_host`

## Requirements
- R1: A request seen while `busy` is low starts a transfer: `cs_n` is low and `busy` is high in the following cycle. A request seen while `busy` is high is ignored, including during the chip-select recovery period when `cs_n` is already high.
- R2: The host shifts out the configuration on `mosi` in the order 1 (start), `req_sgl`, `req_odd`, `req_msbf`, one bit per rising `sclk` edge 1 to 4. `mosi` changes only when `sclk` goes low or when chip select falls.
- R3: `mosi_oe` is high at the 4th rising `sclk` edge and low before the 4th falling edge. It stays low for the rest of the transfer and is low when idle.
- R4: Each `sclk` level lasts HALF_DIV system cycles, so the serial clock period is 2*HALF_DIV cycles. `sclk` is low whenever `cs_n` is high.
- R5: `miso` is sampled at rising `sclk` edges. The value at edge 5 (the null bit) is dropped, and edges 6 to 13 give result bits 7 down to 0.
- R6: `result_valid` is a one-cycle pulse, and `cs_n` returns high in the same cycle. A transfer has 13 rising `sclk` edges when `req_msbf` is 1 and 20 when it is 0.
- R7: When `req_msbf` is 0, the bits sampled at rising edges 14 to 20 are taken as result bits 1 to 7. `mismatch` is raised with `result_valid` if any of them differs from the first copy. `mismatch` stays 0 when `req_msbf` is 1. It keeps its value until the next accepted request clears it.
- R8: Between two transfers, `cs_n` stays high for at least CSH_CYCLES system cycles.
- R9: After reset, `cs_n` is high, `sclk`, `mosi_oe`, `busy`, `result_valid` and `mismatch` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle conversion request |
| req_sgl | input | 1 | 1 = single-ended input, 0 = differential |
| req_odd | input | 1 | Channel or polarity select |
| req_msbf | input | 1 | 1 = MSB-first only, 0 = also read the LSB-first echo |
| busy | output | 1 | Transfer or chip-select recovery in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Configuration data to the converter |
| mosi_oe | output | 1 | Drive enable for `mosi` on a shared data line |
| miso | input | 1 | Data from the converter |
| result | output | 8 | Last conversion result |
| result_valid | output | 1 | One-cycle pulse when `result` updates |
| mismatch | output | 1 | Echo disagreed with the first copy |

## Verification
The assertions assume that `rst_n` starts low and that `miso` is only read at the block's own sampling points. They also assume that HALF_DIV is at least 2, which leaves a whole system cycle between the 4th rising edge and the 4th falling edge for the release of the data line. The bench's converter model drives `miso` only on falling `sclk` edges. It issues requests on falling system-clock edges, either while the block is idle or on purpose while it is busy, so every timing window the checker relies on comes from the design and not from the stimulus.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int RES_W      = 8;
  localparam int CFG_BITS   = 4;
  localparam int EDGE_W     = 5;
  // rising-edge numbers of the frame
  localparam int FIRST_DATA = CFG_BITS + 2;
  localparam int LAST_MSB   = CFG_BITS + 1 + RES_W;
  localparam int FIRST_ECHO = LAST_MSB + 1;
  localparam int LAST_ECHO  = LAST_MSB + RES_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_RECOV = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sadc_clkdiv.sv
module sadc_clkdiv #(
  parameter int HALF_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == CW'(HALF_DIV - 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int CSH_CYCLES = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              cfg_sgl,
  input  logic              cfg_odd,
  input  logic              cfg_msbf,
  input  logic              tick,
  output logic              run,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              mosi_oe,
  output logic              busy,
  output logic              start,
  output logic              rise,
  output logic [EDGE_W-1:0] rise_idx,
  output logic              finish,
  output logic              msbf
);
  localparam int RW = $clog2(CSH_CYCLES + 1);

  seq_state_t        state_q, state_d;
  logic              cs_q, cs_d;
  logic              sclk_q, sclk_d;
  logic              mosi_q, mosi_d;
  logic              oe_q, oe_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic              sgl_q, sgl_d, odd_q, odd_d, msbf_q, msbf_d;
  logic [RW-1:0]     rec_q, rec_d;
  logic [EDGE_W-1:0] last_edge;

  assign run       = (state_q == ST_RUN);
  assign busy      = (state_q != ST_IDLE);
  assign start     = (state_q == ST_IDLE) && req;
  assign rise      = run && tick && !sclk_q;
  assign rise_idx  = edge_q + EDGE_W'(1);
  assign last_edge = msbf_q ? EDGE_W'(LAST_MSB) : EDGE_W'(LAST_ECHO);
  assign finish    = run && tick && sclk_q && (edge_q == last_edge);

  assign cs_n    = cs_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign mosi_oe = oe_q;
  assign msbf    = msbf_q;

  always_comb begin
    state_d = state_q;
    cs_d    = cs_q;
    sclk_d  = sclk_q;
    mosi_d  = mosi_q;
    oe_d    = oe_q;
    edge_d  = edge_q;
    sgl_d   = sgl_q;
    odd_d   = odd_q;
    msbf_d  = msbf_q;
    rec_d   = rec_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          state_d = ST_RUN;
          cs_d    = 1'b0;
          sclk_d  = 1'b0;
          mosi_d  = 1'b1;
          oe_d    = 1'b1;
          edge_d  = '0;
          sgl_d   = cfg_sgl;
          odd_d   = cfg_odd;
          msbf_d  = cfg_msbf;
        end
      end
      ST_RUN: begin
        // hand the line over one cycle after the last configuration edge
        if (sclk_q && (edge_q == EDGE_W'(CFG_BITS))) oe_d = 1'b0;
        if (rise) begin
          sclk_d = 1'b1;
          edge_d = rise_idx;
        end else if (tick) begin
          sclk_d = 1'b0;
          if (finish) begin
            cs_d    = 1'b1;
            mosi_d  = 1'b0;
            rec_d   = '0;
            state_d = ST_RECOV;
          end else if (edge_q == EDGE_W'(1)) begin
            mosi_d = sgl_q;
          end else if (edge_q == EDGE_W'(2)) begin
            mosi_d = odd_q;
          end else if (edge_q == EDGE_W'(3)) begin
            mosi_d = msbf_q;
          end else begin
            mosi_d = 1'b0;
          end
        end
      end
      ST_RECOV: begin
        rec_d = rec_q + RW'(1);
        if (rec_q == RW'(CSH_CYCLES - 1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      oe_q    <= 1'b0;
      edge_q  <= '0;
      sgl_q   <= 1'b0;
      odd_q   <= 1'b0;
      msbf_q  <= 1'b1;
      rec_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      mosi_q  <= mosi_d;
      oe_q    <= oe_d;
      edge_q  <= edge_d;
      sgl_q   <= sgl_d;
      odd_q   <= odd_d;
      msbf_q  <= msbf_d;
      rec_q   <= rec_d;
    end
  end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture
  import sadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rise,
  input  logic [EDGE_W-1:0] rise_idx,
  input  logic              miso,
  input  logic              finish,
  input  logic              msbf,
  output logic [RES_W-1:0]  result,
  output logic              result_valid,
  output logic              mismatch
);
  logic [RES_W-1:0] data_q, data_d;
  logic [RES_W-2:0] echo_q, echo_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             val_q, val_d;
  logic             mis_q, mis_d;
  logic             in_data, in_echo;

  assign in_data = (rise_idx >= EDGE_W'(FIRST_DATA)) && (rise_idx <= EDGE_W'(LAST_MSB));
  assign in_echo = (rise_idx >= EDGE_W'(FIRST_ECHO)) && (rise_idx <= EDGE_W'(LAST_ECHO));

  always_comb begin
    data_d = data_q;
    echo_d = echo_q;
    res_d  = res_q;
    mis_d  = mis_q;
    val_d  = 1'b0;
    if (start) begin
      data_d = '0;
      echo_d = '0;
      mis_d  = 1'b0;
    end
    if (rise && in_data) data_d = {data_q[RES_W-2:0], miso};
    if (rise && in_echo) echo_d = {miso, echo_q[RES_W-2:1]};
    if (finish) begin
      res_d = data_q;
      val_d = 1'b1;
      mis_d = !msbf && (echo_q != data_q[RES_W-1:1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      echo_q <= '0;
      res_q  <= '0;
      val_q  <= 1'b0;
      mis_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      echo_q <= echo_d;
      res_q  <= res_d;
      val_q  <= val_d;
      mis_q  <= mis_d;
    end
  end

  assign result       = res_q;
  assign result_valid = val_q;
  assign mismatch     = mis_q;
endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int HALF_DIV   = 125,
  parameter int CSH_CYCLES = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_sgl,
  input  logic             req_odd,
  input  logic             req_msbf,
  output logic             busy,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  output logic             mosi_oe,
  input  logic             miso,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             mismatch
);
  logic              run, tick, start, rise, finish, msbf;
  logic [EDGE_W-1:0] rise_idx;

  sadc_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  sadc_seq #(.CSH_CYCLES(CSH_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .cfg_sgl  (req_sgl),
    .cfg_odd  (req_odd),
    .cfg_msbf (req_msbf),
    .tick     (tick),
    .run      (run),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .mosi_oe  (mosi_oe),
    .busy     (busy),
    .start    (start),
    .rise     (rise),
    .rise_idx (rise_idx),
    .finish   (finish),
    .msbf     (msbf)
  );

  sadc_capture u_cap (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .rise         (rise),
    .rise_idx     (rise_idx),
    .miso         (miso),
    .finish       (finish),
    .msbf         (msbf),
    .result       (result),
    .result_valid (result_valid),
    .mismatch     (mismatch)
  );
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
  parameter int HALF_DIV   = 125,
  parameter int CSH_CYCLES = 125
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic mosi_oe,
  input logic busy,
  input logic result_valid,
  input logic mismatch
);
  localparam int SW = $clog2(HALF_DIV + 2) + 1;
  localparam int HW = $clog2(CSH_CYCLES + 2) + 1;

  logic          sclk_prev, cs_prev, seen_low;
  logic [SW-1:0] lvl_cnt;
  logic [HW-1:0] hi_cnt;
  logic [5:0]    rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      cs_prev   <= 1'b1;
      seen_low  <= 1'b0;
      lvl_cnt   <= SW'(HALF_DIV);
      hi_cnt    <= '0;
      rises     <= '0;
    end else begin
      sclk_prev <= sclk;
      cs_prev   <= cs_n;
      if (!cs_n) seen_low <= 1'b1;
      if (sclk != sclk_prev)            lvl_cnt <= SW'(1);
      else if (lvl_cnt < SW'(HALF_DIV)) lvl_cnt <= lvl_cnt + SW'(1);
      if (!cs_n)                          hi_cnt <= '0;
      else if (hi_cnt < HW'(CSH_CYCLES)) hi_cnt <= hi_cnt + HW'(1);
      if (cs_n)                    rises <= '0;
      else if (sclk && !sclk_prev) rises <= rises + 6'd1;
    end
  end

  a_r1_cs_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  a_r3_oe_held_at_rise4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !sclk_prev && rises == 6'd3) |-> mosi_oe);

  a_r3_oe_released_by_fall4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && sclk_prev && rises >= 6'd4) |-> !mosi_oe);

  a_r4_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_prev) |-> (lvl_cnt >= SW'(HALF_DIV)));

  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r6_valid_with_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && !cs_prev));

  a_r7_mismatch_rises_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mismatch) |-> result_valid);

  a_r8_cs_high_time: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_prev && seen_low) |-> (hi_cnt >= HW'(CSH_CYCLES)));
endmodule

bind sadc_host sadc_host_chk #(.HALF_DIV(HALF_DIV), .CSH_CYCLES(CSH_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n         (cs_n),
  .sclk         (sclk),
  .mosi_oe      (mosi_oe),
  .busy         (busy),
  .result_valid (result_valid),
  .mismatch     (mismatch)
);

// File: tb/sadc_host_test.sv
module sadc_host_test;
  import sadc_pkg::*;
  localparam int HALF = 125;
  localparam int CSH  = 125;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req, req_sgl, req_odd, req_msbf, miso_m;
  logic busy, cs_n, sclk, mosi, mosi_oe, result_valid, mismatch;
  logic [7:0] result;

  sadc_host #(.HALF_DIV(HALF), .CSH_CYCLES(CSH)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_sgl(req_sgl), .req_odd(req_odd),
    .req_msbf(req_msbf), .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .mosi_oe(mosi_oe), .miso(miso_m), .result(result), .result_valid(result_valid),
    .mismatch(mismatch)
  );

  typedef struct {
    logic [7:0] val;
    logic       mis;
    int         edges;
  } exp_t;

  exp_t sbq[$];
  exp_t mon_e;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  int   cyc = 0;
  int   nvalid = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // converter model
  int         rc = 0;
  int         t_r2 = 0;
  logic [7:0] m_val = 8'h00;
  logic       m_bad = 1'b0, m_s = 1'b0, m_o = 1'b0, m_m = 1'b1;

  initial miso_m = 1'b0;

  always @(negedge cs_n) begin
    rc = 0;
    miso_m = 1'b0;
  end

  always @(posedge sclk) begin
    rc++;
    if (rc == 1) check(mosi == 1'b1, "R2 start bit", mosi, 1);
    if (rc == 2) begin
      check(mosi == m_s, "R2 sgl bit", mosi, m_s);
      t_r2 = cyc;
    end
    if (rc == 3) begin
      check(mosi == m_o, "R2 odd bit", mosi, m_o);
      check(cyc - t_r2 == 2 * HALF, "R4 sclk period", cyc - t_r2, 2 * HALF);
    end
    if (rc == 4) begin
      check(mosi == m_m, "R2 order bit", mosi, m_m);
      check(mosi_oe == 1'b1, "R3 oe at rise 4", mosi_oe, 1);
    end
  end

  always @(negedge sclk) begin
    if (rc == 4) begin
      check(mosi_oe == 1'b0, "R3 oe released by fall 4", mosi_oe, 0);
      miso_m = 1'b0;
    end else if (rc >= 5 && rc <= 12) begin
      miso_m = m_val[12 - rc];
    end else if (rc >= 13 && rc <= 19) begin
      miso_m = m_val[rc - 12] ^ (m_bad && rc == 16);
    end else begin
      miso_m = 1'b0;
    end
    if (rc > 4 && !cs_n) check(mosi_oe == 1'b0, "R3 oe stays low", mosi_oe, 0);
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && result_valid === 1'b1) begin
      nvalid++;
      if (sbq.size() == 0) begin
        check(1'b0, "R6 unexpected valid", 1, 0);
      end else begin
        mon_e = sbq.pop_front();
        check(result == mon_e.val, "R5 result", result, mon_e.val);
        check(mismatch == mon_e.mis, "R7 mismatch", mismatch, mon_e.mis);
        check(cs_n == 1'b1, "R6 cs_n high with valid", cs_n, 1);
        check(rc == mon_e.edges, "R6 rising edge count", rc, mon_e.edges);
      end
    end
  end

  // chip-select high time
  int hi = 0;
  bit seen = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (cs_n) hi++;
      else begin
        if (seen && hi > 0) check(hi >= CSH, "R8 cs high time", hi, CSH);
        seen = 1;
        hi = 0;
      end
    end
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic run_conv(input logic [7:0] v, input logic s, input logic o,
                          input logic m, input logic bad);
    exp_t e;
    wait_idle();
    m_val = v; m_bad = bad; m_s = s; m_o = o; m_m = m;
    e.val = v;
    e.mis = !m && bad;
    e.edges = m ? LAST_MSB : LAST_ECHO;
    sbq.push_back(e);
    req = 1'b1; req_sgl = s; req_odd = o; req_msbf = m;
    @(negedge clk);
    req = 1'b0;
    check(cs_n == 1'b0 && busy == 1'b1, "R1 request accepted", {cs_n, busy}, 1);
    check(mismatch == 1'b0, "R7 cleared by request", mismatch, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_sgl = 1'b0; req_odd = 1'b0; req_msbf = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(cs_n == 1'b1, "R9 cs_n", cs_n, 1);
    check(sclk == 1'b0 && mosi_oe == 1'b0, "R9 sclk/oe", {sclk, mosi_oe}, 0);
    check(busy == 1'b0 && result_valid == 1'b0 && mismatch == 1'b0,
          "R9 busy/valid/mismatch", {busy, result_valid, mismatch}, 0);

    run_conv(8'hA5, 1'b1, 1'b0, 1'b1, 1'b0);
    run_conv(8'h3C, 1'b0, 1'b1, 1'b0, 1'b0);
    run_conv(8'h81, 1'b1, 1'b1, 1'b0, 1'b1);
    wait_idle();
    repeat (50) @(negedge clk);
    check(mismatch == 1'b1, "R7 mismatch held", mismatch, 1);
    run_conv(8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    run_conv(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
    run_conv(8'h5A, 1'b0, 1'b1, 1'b1, 1'b1);

    // R1: requests while busy are ignored
    run_conv(8'h69, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (600) @(negedge clk);
    req = 1'b1; req_sgl = 1'b0; req_odd = 1'b1; req_msbf = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!cs_n) @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    check(cs_n == 1'b1, "R1 request in recovery ignored", cs_n, 1);
    wait_idle();
    repeat (20) @(negedge clk);
    check(cs_n == 1'b1 && busy == 1'b0, "R1 no extra transfer", {cs_n, busy}, 2);
    check(nvalid == 7, "R6 one valid per transfer", nvalid, 7);
    check(sbq.size() == 0, "R5 scoreboard drained", sbq.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule